// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Unlock Gate

This block sits on a simple 32-bit register bus and fronts a small array of one-time-programmable fuse rows. The array is held inside the block as registers that reset to all zeros, the unburnt state. Software loads a command code, a row address and one or two words of write data into registers. It then raises a start bit and polls a status word until the command reports completion. Before the next command it lowers the start bit again.

Burning fuses is refused until software has passed a four-value key through the program-enable command. Each key value takes its own start pulse. A program-disable command closes the gate again. A burn can only turn bits from 0 to 1. Its duration grows with the number of one bits being written, so the latency counts a fixed base plus a fixed cost for each such bit. A row holds one or two 32-bit words, chosen by a parameter.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every register reads zero. Reads return what was written, masked to the field width: control at 0x0 (bit 0 only), command at 0x4 (6 bits), start at 0x8 (bit 0), row address at 0x28 (16 bits), and write data at 0x2C (word 0) and 0x64 (word 1). Status is at 0xC, with bit 1 = done and bit 2 = burn gate open. Fetched data is at 0x10 (word 0) and 0x5C (word 1).
- R2: A command starts only when a bus write takes start bit 0 from 0 to 1 while control bit 0 is 1 and no command is running. A start write under any other condition leaves the status unchanged.
- R3: Starting a command clears done. Done sets exactly when the command finishes: 2 cycles for fetch, and 1 cycle for enable, disable, a refused burn or an unknown code.
- R4: Fetch (code 0x00) copies the addressed row into the fetched-data registers, word 0 to 0x10 and word 1 to 0x5C. The row is selected by the low address bits.
- R5: The gate opens when four enable commands (code 0x02) carry word-0 values 0xF, 0x4, 0x8 and 0xD in that order. It opens at the completion of the fourth and not before.
- R6: An enable command whose value does not match the expected step sends the key tracker back to its first step.
- R7: Disable (code 0x03) closes the gate and clears the key tracker. A new four-value key is then needed.
- R8: Burn (code 0x08) with the gate open sets the addressed row to its old value ORed with the write data. No bit ever returns to 0.
- R9: A burn with the gate open takes BASE_CYCLES plus PER_BIT_CYCLES times the number of one bits across the row's write-data words.
- R10: A burn with the gate closed completes with done after 1 cycle and leaves the array unchanged.
- R11: A command code outside the four above completes with done after 1 cycle and changes neither the array nor the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |

## Verification
The assertions assume that software never starts a command while another is running and that it lowers the start bit between commands. The bench's command task keeps to this order: it writes the code, raises start, polls status until done, then lowers start. Held-start and control-off launches are the only deliberate departures, and they are checked at the status port. Row addresses stay inside the configured depth, so the low-bit row selection never aliases during the sweep.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
// Shared constants for the fuse controller: register offsets, command
// codes and the unlock key. Assumes a byte-offset bus of 8 address bits.
package otp_fuse_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_CMD    = 8'h04;
    localparam logic [7:0] OFS_START  = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_ROWSEL = 8'h28;

    localparam logic [5:0] OP_FETCH   = 6'h00;
    localparam logic [5:0] OP_UNLOCK  = 6'h02;
    localparam logic [5:0] OP_LOCK    = 6'h03;
    localparam logic [5:0] OP_BURN    = 6'h08;

    // Offset of fetched-data word w.
    function automatic logic [7:0] fetch_ofs(input int w);
        return (w == 0) ? 8'h10 : 8'h5C;
    endfunction

    // Offset of write-data word w.
    function automatic logic [7:0] load_ofs(input int w);
        return (w == 0) ? 8'h2C : 8'h64;
    endfunction

    // Expected key value at tracker step s.
    function automatic logic [31:0] key_value(input logic [1:0] s);
        case (s)
            2'd0:    return 32'hF;
            2'd1:    return 32'h4;
            2'd2:    return 32'h8;
            default: return 32'hD;
        endcase
    endfunction
endpackage

// File: rtl/otp_unlock_tracker.sv
`timescale 1ns/1ps
// Follows the four-step unlock key and holds the burn gate.
// Assumes step_fire and lock_fire are single-cycle and never coincide.
module otp_unlock_tracker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_fire,
    input  logic        lock_fire,
    input  logic [31:0] key_in,
    output logic        gate_open
);
    import otp_fuse_pkg::*;

    logic [1:0] step_q;
    logic       open_q;

    // Advance, restart or close the key tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 2'd0;
            open_q <= 1'b0;
        end else if (lock_fire) begin
            step_q <= 2'd0;
            open_q <= 1'b0;
        end else if (step_fire) begin
            if (key_in == key_value(step_q)) begin
                if (step_q == 2'd3) open_q <= 1'b1;
                step_q <= step_q + 2'd1;
            end else begin
                step_q <= 2'd0;
            end
        end
    end

    assign gate_open = open_q;

    // R5
    gate_opens_on_last_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(step_fire && step_q == 2'd3));
    // R7
    lock_closes_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fire |=> (!open_q && step_q == 2'd0));
endmodule

// File: rtl/otp_fuse_array.sv
`timescale 1ns/1ps
// Register model of the fuse rows: all bits reset to 0, a burn ORs bits in.
// Assumes burn_idx is held stable in the cycle burn_en is asserted.
module otp_fuse_array #(
    parameter int ROW_BITS  = 64,
    parameter int ADDR_BITS = 4,
    localparam int DEPTH    = 1 << ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 burn_en,
    input  logic [ADDR_BITS-1:0] burn_idx,
    input  logic [ROW_BITS-1:0]  burn_bits,
    output logic [ROW_BITS-1:0]  row_out
);
    logic [ROW_BITS-1:0] cell_q [DEPTH];

    // Clear on reset, OR in burn bits on a burn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) cell_q[r] <= '0;
        end else if (burn_en) begin
            cell_q[burn_idx] <= cell_q[burn_idx] | burn_bits;
        end
    end

    assign row_out = cell_q[burn_idx];

    // R8
    burn_keeps_and_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn_en |=> (((cell_q[$past(burn_idx)] & $past(row_out)) == $past(row_out)) &&
                     ((cell_q[$past(burn_idx)] & $past(burn_bits)) == $past(burn_bits))));
endmodule

// File: rtl/otp_cmd_engine.sv
`timescale 1ns/1ps
// Runs one command at a time: latches operands at launch, counts the
// latency and pulses one finish strobe. Assumes launch only while idle.
module otp_cmd_engine #(
    parameter int ROW_BITS       = 64,
    parameter int ADDR_BITS      = 4,
    parameter int BASE_CYCLES    = 6,
    parameter int PER_BIT_CYCLES = 2,
    parameter int FETCH_CYCLES   = 2,
    localparam int ONES_W = $clog2(ROW_BITS + 1),
    localparam int CNT_W  = $clog2(BASE_CYCLES + PER_BIT_CYCLES * ROW_BITS + FETCH_CYCLES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [5:0]           op_code,
    input  logic [ADDR_BITS-1:0] op_idx_in,
    input  logic [ROW_BITS-1:0]  op_row_in,
    input  logic                 gate_open,
    output logic                 busy,
    output logic                 done,
    output logic [ADDR_BITS-1:0] op_idx,
    output logic [ROW_BITS-1:0]  op_row,
    output logic                 key_fire,
    output logic                 lock_fire,
    output logic                 burn_fire,
    output logic                 fetch_fire
);
    import otp_fuse_pkg::*;

    logic [ONES_W-1:0]    ones;
    logic [CNT_W-1:0]     lat_d;
    logic [CNT_W-1:0]     cnt_q;
    logic                 busy_q, done_q, allow_q;
    logic [5:0]           code_q;
    logic [ADDR_BITS-1:0] idx_q;
    logic [ROW_BITS-1:0]  row_q;
    logic                 fin;

    // Count the one bits that a burn would write.
    always_comb begin
        ones = '0;
        for (int b = 0; b < ROW_BITS; b++) ones = ones + ONES_W'(op_row_in[b]);
    end

    // Pick the latency of the command being launched.
    always_comb begin
        if (op_code == OP_FETCH)
            lat_d = CNT_W'(FETCH_CYCLES);
        else if (op_code == OP_BURN && gate_open)
            lat_d = CNT_W'(BASE_CYCLES) + CNT_W'(PER_BIT_CYCLES) * CNT_W'(ones);
        else
            lat_d = CNT_W'(1);
    end

    assign fin = busy_q && (cnt_q == CNT_W'(1));

    // Launch, count down and finish the running command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            allow_q <= 1'b0;
            cnt_q   <= '0;
            code_q  <= '0;
            idx_q   <= '0;
            row_q   <= '0;
        end else if (launch) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            allow_q <= gate_open;
            cnt_q   <= lat_d;
            code_q  <= op_code;
            idx_q   <= op_idx_in;
            row_q   <= op_row_in;
        end else if (fin) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy       = busy_q;
    assign done       = done_q;
    assign op_idx     = idx_q;
    assign op_row     = row_q;
    assign key_fire   = fin && code_q == OP_UNLOCK;
    assign lock_fire  = fin && code_q == OP_LOCK;
    assign burn_fire  = fin && code_q == OP_BURN && allow_q;
    assign fetch_fire = fin && code_q == OP_FETCH;

    // R3
    launch_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy_q && !done_q));
    // R3
    finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (done_q && !busy_q));
    // R2
    idle_done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !launch) |=> $stable(done_q));
    // R2
    launch_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy_q);
endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
// Register front end of the fuse controller. Decodes the bus, detects the
// start edge and wires engine, key tracker and fuse array together.
// Assumes ROW_WORDS is 1 or 2 and the bus holds one access per cycle.
module otp_fuse_ctrl #(
    parameter int ROW_WORDS      = 2,
    parameter int ADDR_BITS      = 4,
    parameter int BASE_CYCLES    = 6,
    parameter int PER_BIT_CYCLES = 2,
    parameter int FETCH_CYCLES   = 2,
    localparam int ROW_BITS      = 32 * ROW_WORDS
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    import otp_fuse_pkg::*;

    logic                 ctrl_q, start_q;
    logic [5:0]           code_q;
    logic [15:0]          rowsel_q;
    logic [31:0]          load_q  [ROW_WORDS];
    logic [31:0]          fetch_q [ROW_WORDS];
    logic [ROW_BITS-1:0]  load_row, op_row, array_row;
    logic [ADDR_BITS-1:0] op_idx;
    logic                 wr, launch, busy, done, gate_open;
    logic                 key_fire, lock_fire, burn_fire, fetch_fire;

    assign wr = bus_en && bus_we;
    assign launch = wr && bus_addr == OFS_START && bus_wdata[0] && !start_q && ctrl_q && !busy;

    // Pack the write-data words into one row.
    always_comb begin
        for (int w = 0; w < ROW_WORDS; w++) load_row[w*32 +: 32] = load_q[w];
    end

    // Software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= 1'b0;
            start_q  <= 1'b0;
            code_q   <= '0;
            rowsel_q <= '0;
            for (int w = 0; w < ROW_WORDS; w++) load_q[w] <= '0;
        end else if (wr) begin
            if (bus_addr == OFS_CTRL)   ctrl_q   <= bus_wdata[0];
            if (bus_addr == OFS_START)  start_q  <= bus_wdata[0];
            if (bus_addr == OFS_CMD)    code_q   <= bus_wdata[5:0];
            if (bus_addr == OFS_ROWSEL) rowsel_q <= bus_wdata[15:0];
            for (int w = 0; w < ROW_WORDS; w++)
                if (bus_addr == load_ofs(w)) load_q[w] <= bus_wdata;
        end
    end

    // Fetched-data registers, loaded when a fetch finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < ROW_WORDS; w++) fetch_q[w] <= '0;
        end else if (fetch_fire) begin
            for (int w = 0; w < ROW_WORDS; w++) fetch_q[w] <= array_row[w*32 +: 32];
        end
    end

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == OFS_CTRL)   bus_rdata = {31'b0, ctrl_q};
            if (bus_addr == OFS_START)  bus_rdata = {31'b0, start_q};
            if (bus_addr == OFS_CMD)    bus_rdata = {26'b0, code_q};
            if (bus_addr == OFS_ROWSEL) bus_rdata = {16'b0, rowsel_q};
            if (bus_addr == OFS_STATUS) bus_rdata = {29'b0, gate_open, done, 1'b0};
            for (int w = 0; w < ROW_WORDS; w++) begin
                if (bus_addr == load_ofs(w))  bus_rdata = load_q[w];
                if (bus_addr == fetch_ofs(w)) bus_rdata = fetch_q[w];
            end
        end
    end

    otp_cmd_engine #(
        .ROW_BITS(ROW_BITS), .ADDR_BITS(ADDR_BITS), .BASE_CYCLES(BASE_CYCLES),
        .PER_BIT_CYCLES(PER_BIT_CYCLES), .FETCH_CYCLES(FETCH_CYCLES)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .launch(launch), .op_code(code_q),
        .op_idx_in(rowsel_q[ADDR_BITS-1:0]), .op_row_in(load_row),
        .gate_open(gate_open), .busy(busy), .done(done), .op_idx(op_idx),
        .op_row(op_row), .key_fire(key_fire), .lock_fire(lock_fire),
        .burn_fire(burn_fire), .fetch_fire(fetch_fire)
    );

    otp_unlock_tracker u_tracker (
        .clk(clk), .rst_n(rst_n), .step_fire(key_fire), .lock_fire(lock_fire),
        .key_in(op_row[31:0]), .gate_open(gate_open)
    );

    otp_fuse_array #(.ROW_BITS(ROW_BITS), .ADDR_BITS(ADDR_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .burn_en(burn_fire), .burn_idx(op_idx),
        .burn_bits(op_row), .row_out(array_row)
    );

    // R10
    locked_no_burn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burn_fire |-> gate_open);
    // R2
    ctrl_off_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q && !busy) |=> !busy);
endmodule

// File: tb/otp_fuse_ctrl_test.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_test;
    localparam int BASE = 6;
    localparam int PERB = 2;
    localparam int FETCH = 2;
    localparam int ROWS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int vectors = 0;
    int misses = 0;
    int ref_step = 0;
    bit ref_open = 0;
    logic [31:0] ref_w0 [ROWS];
    logic [31:0] ref_w1 [ROWS];

    always #2 clk = ~clk;

    otp_fuse_ctrl #(.ROW_WORDS(2), .ADDR_BITS(4), .BASE_CYCLES(BASE),
                    .PER_BIT_CYCLES(PERB), .FETCH_CYCLES(FETCH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_rd(a, v);
        check(v == exp, tag, v, exp);
    endtask

    // Issue a command, measure cycles from the start edge to done, compare.
    task automatic run_cmd(input logic [5:0] c, input int exp_lat, input string tag);
        logic [31:0] s;
        int n;
        bus_wr(8'h04, {26'b0, c});
        bus_wr(8'h08, 32'h1);
        n = 0;
        forever begin
            bus_rd(8'h0C, s);
            if (s[1] || n > 400) break;
            @(posedge clk);
            n++;
        end
        check(n == exp_lat, tag, n, exp_lat);
        bus_wr(8'h08, 32'h0);
    endtask

    task automatic key_step(input logic [31:0] v);
        bus_wr(8'h2C, v);
        run_cmd(6'h02, 1, "R3 enable latency");
        if (v == ((ref_step == 0) ? 32'hF : (ref_step == 1) ? 32'h4 : (ref_step == 2) ? 32'h8 : 32'hD)) begin
            if (ref_step == 3) ref_open = 1;
            ref_step = (ref_step + 1) % 4;
        end else ref_step = 0;
        expect_reg(8'h0C, {29'b0, ref_open, 2'b10}, "R5 R6 gate after key step");
    endtask

    task automatic burn_row(input int r, input logic [31:0] a, input logic [31:0] b);
        int lat;
        bus_wr(8'h28, r);
        bus_wr(8'h2C, a);
        bus_wr(8'h64, b);
        lat = ref_open ? BASE + PERB * ($countones(a) + $countones(b)) : 1;
        run_cmd(6'h08, lat, ref_open ? "R9 burn latency" : "R10 locked burn latency");
        if (ref_open) begin
            ref_w0[r] = ref_w0[r] | a;
            ref_w1[r] = ref_w1[r] | b;
        end
    endtask

    task automatic fetch_row(input int r, input string tag);
        bus_wr(8'h28, r);
        run_cmd(6'h00, FETCH, "R3 fetch latency");
        expect_reg(8'h10, ref_w0[r], tag);
        expect_reg(8'h5C, ref_w1[r], tag);
    endtask

    initial begin
        #(4 * 150000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin ref_w0[r] = '0; ref_w1[r] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_reg(8'h00, 0, "R1 reset ctrl");
        expect_reg(8'h04, 0, "R1 reset cmd");
        expect_reg(8'h0C, 0, "R1 reset status");
        expect_reg(8'h28, 0, "R1 reset rowsel");
        expect_reg(8'h10, 0, "R1 reset fetch0");

        // R1 readback masking
        bus_wr(8'h04, 32'hFFFF_FFFF); expect_reg(8'h04, 32'h3F, "R1 cmd mask");
        bus_wr(8'h28, 32'h0012_3456); expect_reg(8'h28, 32'h3456, "R1 rowsel mask");
        bus_wr(8'h2C, 32'hA5A5_0F0F); expect_reg(8'h2C, 32'hA5A5_0F0F, "R1 load0");
        bus_wr(8'h64, 32'h1234_5678); expect_reg(8'h64, 32'h1234_5678, "R1 load1");
        bus_wr(8'h00, 32'hFFFF_FFFF); expect_reg(8'h00, 32'h1, "R1 ctrl mask");

        // R2 control off: start edge ignored
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h08, 32'h1);
        repeat (5) @(posedge clk);
        expect_reg(8'h0C, 0, "R2 ctrl off no launch");
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h00, 32'h1);

        // R4 R10 fetch fresh row, refused burn
        fetch_row(3, "R4 fresh row");
        burn_row(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        fetch_row(3, "R10 locked burn leaves row");

        // R2 done stays set when start is rewritten while high, or ctrl is off
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h08, 32'h1);
        repeat (FETCH + 2) @(posedge clk);
        bus_wr(8'h08, 32'h1);
        expect_reg(8'h0C, 32'h2, "R2 held start no relaunch");
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h08, 32'h1);
        expect_reg(8'h0C, 32'h2, "R2 ctrl off status unchanged");
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h00, 32'h1);

        // R6 broken key, then repeated first value
        key_step(32'hF); key_step(32'h4); key_step(32'h7); key_step(32'h8); key_step(32'hD);
        key_step(32'hF); key_step(32'hF); key_step(32'h4);
        expect_reg(8'h0C, 32'h2, "R6 gate closed after bad key");
        // R5 correct key
        key_step(32'hF); key_step(32'h4); key_step(32'h8);
        expect_reg(8'h0C, 32'h2, "R5 gate closed before last value");
        key_step(32'hD);
        expect_reg(8'h0C, 32'h6, "R5 gate open");

        // R11 unknown code
        run_cmd(6'h3F, 1, "R11 unknown latency");
        expect_reg(8'h0C, 32'h6, "R11 gate unchanged");

        // R8 R9 sweep every row with two overlapping burns
        for (int r = 0; r < ROWS; r++) begin
            logic [31:0] a, b;
            a = (r == 15) ? 32'hFFFF_FFFF : ((32'h1 << (2 * r)) - 32'h1);
            b = 32'h0101_0101 * r;
            burn_row(r, a, b);
            burn_row(r, 32'h8000_0000 >> r, (r == 15) ? 32'hFFFF_FFFF : ~b & 32'h00FF_00FF);
        end
        for (int r = 0; r < ROWS; r++) fetch_row(r, "R8 row after OR burns");

        // R7 disable closes gate, burn then refused
        run_cmd(6'h03, 1, "R7 disable latency");
        ref_open = 0; ref_step = 0;
        expect_reg(8'h0C, 32'h2, "R7 gate closed");
        burn_row(0, 32'h0000_FFFF, 32'h0);
        fetch_row(0, "R10 burn after disable");
        key_step(32'h4);
        key_step(32'hF); key_step(32'h4); key_step(32'h8); key_step(32'hD);
        expect_reg(8'h0C, 32'h6, "R7 reopen with full key");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule